// File: doc/BRIEF.md
# Serial PLL Configuration Shifter

This block loads the divider settings of an external frequency-synthesizer chip over a bit-serial link. One load strobe presents five divider fields: a 7-bit feedback count, a 7-bit reference count, a 1-bit VCO range select, a 1-bit crystal select and a 2-bit output divider. The block packs these fields with a fixed 5-bit constant into a 24-bit programming word. It sends the word least significant bit first, one bit for each serial-clock pulse. A hold line marks the final bit. After the last bit a separate latch strobe tells the synthesizer to take the new word.

Each serial-clock phase lasts `SCLK_HALF` system clocks, so the link speed can be matched to the synthesizer chip. The block reports busy for the whole sequence and gives a one-cycle done pulse at the end. A new load strobe is accepted only when the block is idle. Working out divider values from a target frequency is left to the agent that drives the block.

Top module: `pll_cfg_shifter`

## Requirements
- R1: The programming word has the feedback count in bits 6:0, the reference count in bits 13:7, the VCO range bit in bit 14, the crystal select in bit 15, a zero in bit 16, the output divider in bits 18:17 and the constant 5'h17 in bits 23:19.
- R2: Exactly 24 bits go out per load, bit 0 first. Each bit sits on `ser_data_o` through the low phase and the high phase of its serial-clock pulse, and the receiver samples it on the rising edge of `ser_clk_o`.
- R3: `hold_o` is high during the 24th bit only, through both of its phases, and low for every other bit.
- R4: Every bit is a low phase of `SCLK_HALF` system clocks followed by a high phase of `SCLK_HALF` system clocks. The first low phase begins in the cycle after the load is accepted.
- R5: In the cycle after the last high phase, `latch_o` goes high for 2*`SCLK_HALF` cycles. During that pulse `ser_clk_o`, `ser_data_o` and `hold_o` are low.
- R6: `busy_o` is high from the cycle after an accepted load through the done cycle. A load strobe that arrives while `busy_o` is high, including during the done cycle, is ignored: it changes neither the word being sent nor starts a new sequence.
- R7: `done_o` is a one-cycle pulse in the cycle right after the latch pulse ends, and `busy_o` is low in the following cycle. The done pulse therefore comes 50*`SCLK_HALF` cycles after the first shifting cycle.
- R8: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Start strobe; the field inputs are captured with it when idle |
| fb_cnt_i | input | 7 | Feedback divider count |
| ref_cnt_i | input | 7 | Reference divider count |
| vco_sel_i | input | 1 | VCO range select |
| xtal_sel_i | input | 1 | Crystal select |
| out_div_i | input | 2 | Output divider select |
| ser_data_o | output | 1 | Serial data bit |
| ser_clk_o | output | 1 | Serial clock |
| hold_o | output | 1 | Marks the final bit of the word |
| latch_o | output | 1 | Latch strobe sent after the word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The hardest case to reach is a load strobe that lands exactly in the done cycle. In that cycle `busy_o` is still high, but one cycle later a strobe would be accepted. The bench watches the done pulse as it happens and raises the strobe in that same sampled cycle, with different fields. It then checks that no new serial clock appears and that `busy_o` stays low. A second test raises a load with other fields partway through the shift and checks that the captured word still matches the first fields.

// File: rtl/pll_cfg_pkg.sv
// Shared widths, constant and types for the serial PLL configuration shifter.
package pll_cfg_pkg;
    localparam int WORD_W    = 24;
    localparam int FB_W      = 7;
    localparam int REF_W     = 7;
    localparam int ODIV_W    = 2;
    localparam int CONST_W   = 5;
    localparam int IDX_W     = $clog2(WORD_W);
    localparam logic [CONST_W-1:0] SYNTH_CONST = 5'h17;
    localparam logic [IDX_W-1:0]   LAST_IDX    = IDX_W'(WORD_W - 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LATCH = 2'd2,
        ST_FIN   = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic [ODIV_W-1:0] out_div;
        logic              xtal_sel;
        logic              vco_sel;
        logic [REF_W-1:0]  ref_cnt;
        logic [FB_W-1:0]   fb_cnt;
    } div_fields_t;
endpackage

// File: rtl/pll_cfg_pack.sv
// Packs the divider fields into the 24-bit programming word.
// Assumes the field widths in pll_cfg_pkg; purely combinational.
module pll_cfg_pack
    import pll_cfg_pkg::*;
(
    input  div_fields_t        fields_i,
    output logic [WORD_W-1:0]  word_o
);
    // Fixed layout: constant on top, bit 16 forced low.
    always_comb begin
        word_o = {SYNTH_CONST, fields_i.out_div, 1'b0, fields_i.xtal_sel,
                  fields_i.vco_sel, fields_i.ref_cnt, fields_i.fb_cnt};
    end
endmodule

// File: rtl/pll_cfg_timer.sv
// Phase timer: while run_i is high, tick_o pulses every HALF cycles.
// Assumes HALF >= 1; the count restarts whenever run_i is low.
module pll_cfg_timer #(
    parameter int HALF = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] TERM = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    // Tick on the terminal count of the running phase.
    always_comb tick_o = run_i && (cnt_q == TERM);

    // Count system clocks inside a phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i || tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // Keeps the counter inside one phase length.
    assert_phase_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (int'(cnt_q) < HALF));
endmodule

// File: rtl/pll_cfg_seq.sv
// Sequencer: takes in a word on an idle load, shifts it out LSB first as
// serial-clock pulses, marks the final bit with hold, then sends the latch
// strobe and a done pulse. Assumes tick_i comes from a timer run by run_o.
module pll_cfg_seq
    import pll_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              tick_i,
    output logic              run_o,
    output logic              ser_data_o,
    output logic              ser_clk_o,
    output logic              hold_o,
    output logic              latch_o,
    output logic              busy_o,
    output logic              done_o
);
    seq_state_t        state_q;
    logic [WORD_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic              phase_hi_q;
    logic              lat_second_q;

    // Main sequence: idle, shift bits, latch, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            shreg_q      <= '0;
            idx_q        <= '0;
            phase_hi_q   <= 1'b0;
            lat_second_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (load_i) begin
                        state_q    <= ST_SHIFT;
                        shreg_q    <= word_i;
                        idx_q      <= '0;
                        phase_hi_q <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (tick_i) begin
                        if (!phase_hi_q) begin
                            phase_hi_q <= 1'b1;
                        end else begin
                            phase_hi_q <= 1'b0;
                            if (idx_q == LAST_IDX) begin
                                state_q      <= ST_LATCH;
                                lat_second_q <= 1'b0;
                            end else begin
                                idx_q   <= idx_q + 1'b1;
                                shreg_q <= shreg_q >> 1;
                            end
                        end
                    end
                end
                ST_LATCH: begin
                    if (tick_i) begin
                        if (!lat_second_q)
                            lat_second_q <= 1'b1;
                        else
                            state_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the registered state.
    always_comb begin
        run_o      = (state_q == ST_SHIFT) || (state_q == ST_LATCH);
        ser_clk_o  = (state_q == ST_SHIFT) && phase_hi_q;
        ser_data_o = (state_q == ST_SHIFT) && shreg_q[0];
        hold_o     = (state_q == ST_SHIFT) && (idx_q == LAST_IDX);
        latch_o    = (state_q == ST_LATCH);
        busy_o     = (state_q != ST_IDLE);
        done_o     = (state_q == ST_FIN);
    end

    // Data and hold must be settled before the receiver's sampling edge.
    assert_data_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk_o) |-> ($stable(ser_data_o) && $stable(hold_o)));

    // The latch strobe must follow a bit that carried hold.
    assert_hold_before_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_o) |-> $past(hold_o));

    // Serial lines stay quiet while the latch strobe is out.
    assert_latch_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |-> (!ser_clk_o && !ser_data_o && !hold_o));

    // Busy may only drop after the done pulse.
    assert_busy_until_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // Done follows the latch strobe and is the last busy cycle.
    assert_done_after_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(latch_o) && !latch_o));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
endmodule

// File: rtl/pll_cfg_shifter.sv
// Top of the serial PLL configuration shifter. Joins the field packer,
// the phase timer and the sequencer. SCLK_HALF sets the number of system
// clocks per serial-clock phase (at least 1).
module pll_cfg_shifter
    import pll_cfg_pkg::*;
#(
    parameter int SCLK_HALF = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [FB_W-1:0]   fb_cnt_i,
    input  logic [REF_W-1:0]  ref_cnt_i,
    input  logic              vco_sel_i,
    input  logic              xtal_sel_i,
    input  logic [ODIV_W-1:0] out_div_i,
    output logic              ser_data_o,
    output logic              ser_clk_o,
    output logic              hold_o,
    output logic              latch_o,
    output logic              busy_o,
    output logic              done_o
);
    div_fields_t        fields;
    logic [WORD_W-1:0]  word;
    logic               run;
    logic               tick;

    // Gather the field inputs into one struct.
    always_comb begin
        fields.fb_cnt   = fb_cnt_i;
        fields.ref_cnt  = ref_cnt_i;
        fields.vco_sel  = vco_sel_i;
        fields.xtal_sel = xtal_sel_i;
        fields.out_div  = out_div_i;
    end

    pll_cfg_pack u_pack (
        .fields_i (fields),
        .word_o   (word)
    );

    pll_cfg_timer #(.HALF(SCLK_HALF)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    pll_cfg_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .word_i     (word),
        .tick_i     (tick),
        .run_o      (run),
        .ser_data_o (ser_data_o),
        .ser_clk_o  (ser_clk_o),
        .hold_o     (hold_o),
        .latch_o    (latch_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );
endmodule

// File: tb/test_pll_cfg_shifter.sv
// Directed bench for pll_cfg_shifter: one task per scenario.
module test_pll_cfg_shifter;
    localparam int H = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [6:0] fb = '0;
    logic [6:0] rf = '0;
    logic       vs = 1'b0;
    logic       xs = 1'b0;
    logic [1:0] od = '0;
    logic ser_data_o, ser_clk_o, hold_o, latch_o, busy_o, done_o;

    int checks = 0;
    int errors = 0;

    // Frame capture results.
    logic [23:0] cap_word;
    logic [23:0] cap_hold;
    int nbits, lo_bad, hi_bad, lat_len, lat_bad, done_n, done_cyc, busy_bad, idle_bad;

    always #10 clk = ~clk;

    pll_cfg_shifter #(.SCLK_HALF(H)) i_pll_cfg_shifter (
        .clk(clk), .rst_n(rst_n), .load_i(load_i),
        .fb_cnt_i(fb), .ref_cnt_i(rf), .vco_sel_i(vs), .xtal_sel_i(xs), .out_div_i(od),
        .ser_data_o(ser_data_o), .ser_clk_o(ser_clk_o), .hold_o(hold_o),
        .latch_o(latch_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] expect_word(input logic [6:0] f, input logic [6:0] r,
                                                input logic v, input logic x, input logic [1:0] o);
        logic [23:0] w;
        w = '0;
        w[6:0]   = f;
        w[13:7]  = r;
        w[14]    = v;
        w[15]    = x;
        w[18:17] = o;
        w[23:19] = 5'h17;
        return w;
    endfunction

    // Starts a frame and records it. inj_at >= 0 raises load with other
    // fields in that sampled cycle; inj_at == -2 raises it in the done cycle.
    task automatic run_frame(input logic [6:0] f, input logic [6:0] r, input logic v,
                             input logic x, input logic [1:0] o, input int inj_at);
        logic prev_clk = 1'b0;
        int lo = 0;
        int hi = 0;
        cap_word = '0; cap_hold = '0;
        nbits = 0; lo_bad = 0; hi_bad = 0; lat_len = 0; lat_bad = 0;
        done_n = 0; done_cyc = -1; busy_bad = 0; idle_bad = 0;
        @(negedge clk);
        fb = f; rf = r; vs = v; xs = x; od = o; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            if (!busy_o) busy_bad++;
            if (ser_clk_o) begin
                if (!prev_clk) begin
                    if (lo != H) lo_bad++;
                    lo = 0;
                    if (nbits < 24) begin
                        cap_word[nbits] = ser_data_o;
                        cap_hold[nbits] = hold_o;
                    end
                    nbits++;
                end
                hi++;
            end else begin
                if (prev_clk) begin
                    if (hi != H) hi_bad++;
                    hi = 0;
                end
                if (!latch_o && !done_o) lo++;
            end
            if (latch_o) begin
                lat_len++;
                if (ser_clk_o || ser_data_o || hold_o) lat_bad++;
            end
            prev_clk = ser_clk_o;
            if (cyc == inj_at || (inj_at == -2 && done_o)) begin
                fb = ~f; rf = ~r; vs = ~v; xs = ~x; od = ~o; load_i = 1'b1;
            end else begin
                load_i = 1'b0;
            end
            if (done_o) begin
                done_n++;
                done_cyc = cyc;
                @(negedge clk);
                load_i = 1'b0;
                break;
            end
            @(negedge clk);
        end
        // Idle check after the frame: nothing should restart.
        for (int k = 0; k < 4 * H; k++) begin
            if (busy_o || ser_clk_o || latch_o || done_o) idle_bad++;
            @(negedge clk);
        end
    endtask

    task automatic check_frame(input logic [23:0] exp_w);
        chk(cap_word == exp_w, "R1 word", cap_word, exp_w);
        chk(cap_word[16] == 1'b0, "R1 bit16", cap_word[16], 0);
        chk(nbits == 24, "R2 bit count", nbits, 24);
        chk(cap_hold == 24'h800000, "R3 hold mask", cap_hold, 24'h800000);
        chk(lo_bad == 0 && hi_bad == 0, "R4 phase length", lo_bad + hi_bad, 0);
        chk(lat_len == 2 * H, "R5 latch length", lat_len, 2 * H);
        chk(lat_bad == 0, "R5 latch quiet", lat_bad, 0);
        chk(busy_bad == 0, "R6 busy held", busy_bad, 0);
        chk(done_n == 1 && done_cyc == 50 * H, "R7 done timing", done_cyc, 50 * H);
        chk(idle_bad == 0, "R7 idle after done", idle_bad, 0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({ser_data_o, ser_clk_o, hold_o, latch_o, busy_o, done_o} == 6'b0,
            "R8 outputs in reset", {ser_data_o, ser_clk_o, hold_o, latch_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ser_data_o, ser_clk_o, hold_o, latch_o, busy_o, done_o} == 6'b0,
            "R8 outputs after reset", {ser_data_o, ser_clk_o, hold_o, latch_o, busy_o, done_o}, 0);
    endtask

    task automatic test_pattern(input logic [6:0] f, input logic [6:0] r, input logic v,
                                input logic x, input logic [1:0] o);
        run_frame(f, r, v, x, o, -1);
        check_frame(expect_word(f, r, v, x, o));
    endtask

    task automatic test_load_mid_shift();
        run_frame(7'h2d, 7'h2b, 1'b1, 1'b1, 2'd1, 20 * H + 1);
        check_frame(expect_word(7'h2d, 7'h2b, 1'b1, 1'b1, 2'd1));
        chk(cap_word == expect_word(7'h2d, 7'h2b, 1'b1, 1'b1, 2'd1), "R6 load ignored mid shift",
            cap_word, expect_word(7'h2d, 7'h2b, 1'b1, 1'b1, 2'd1));
    endtask

    task automatic test_load_on_done();
        run_frame(7'h40, 7'h07, 1'b0, 1'b1, 2'd1, -2);
        check_frame(expect_word(7'h40, 7'h07, 1'b0, 1'b1, 2'd1));
        chk(idle_bad == 0, "R6 load in done cycle ignored", idle_bad, 0);
    endtask

    initial begin
        test_reset();
        test_pattern(7'h00, 7'h00, 1'b0, 1'b0, 2'd0);
        test_pattern(7'h7f, 7'h7f, 1'b1, 1'b1, 2'd3);
        test_pattern(7'h55, 7'h2a, 1'b0, 1'b1, 2'd2);
        test_pattern(7'h6e, 7'h15, 1'b1, 1'b0, 2'd1);
        test_load_mid_shift();
        test_load_on_done();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule